// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a 16-bit up-counter with a clock divider and up to four compare channels, controlled through a small word-addressed register bus. Software picks a divide ratio, a counting mode and a counter top. It loads a compare value per channel and a 2-bit interrupt level per channel. Each channel latches a flag when the counter arrives on its compare value, and raises an interrupt request while that flag is set and its level is nonzero. Flags are cleared either by a write-one-to-clear access or by a per-channel acknowledge pulse from the interrupt controller.

There are two counting modes. In normal mode the counter wraps to zero after it reaches the period register. In frequency mode the channel 0 compare value is the top instead, which produces a repeating channel 0 match at a programmable rate. A command register gives a full reset of the block's registers and a restart that only zeroes the counter and the divider phase.

Register map (word addresses, 16-bit data): 0 clock select [2:0], 1 mode [0] (0 normal, 1 frequency), 2 command (write only, bit0 reset, bit1 restart), 3 period, 4 counter, 5 interrupt levels, 6 flags, 8+n compare value of channel n. Unused addresses and unused bits read as zero.

Top module: `mctimer`

## Requirements
- R1: After rst_n the clock select, mode, levels, flags, counter and compare values read 0, the period reads 0xFFFF, and no interrupt request is raised.
- R2: With clock select 0 the counter holds its value.
- R3: Clock select values 1 to 7 step the counter once every 1, 2, 4, 8, 64, 256 and 1024 clocks respectively. Any write to the clock select clears the divider, so the first step comes a full division period after the write edge.
- R4: In normal mode (mode bit0 = 0) the counter counts 0, 1, ... up to the period value and then steps to 0.
- R5: In frequency mode (mode bit0 = 1) the channel 0 compare value replaces the period as the counter top.
- R6: Flag bit n (flags register bit n) is set on the clock edge at which the counter steps onto the compare value of channel n. Loads of the counter over the bus do not set flags.
- R7: The level of channel n sits at levels register bits [2n+1:2n] and is driven on irq_level at the same bits. irq_req[n] is high while flag n is set and that level is nonzero.
- R8: Writing the flags register clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A flag set in the same cycle wins over the clear.
- R9: A high irq_ack[n] for one cycle clears flag n.
- R10: A bus write to the counter loads the written value on that edge, replacing the step of that cycle.
- R11: Writing the command register with bit0 set returns every register, the counter, the flags and the divider to their reset values.
- R12: Writing the command register with bit1 set (bit0 clear) zeroes the counter and the divider phase and keeps all other registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | ADDR_W (5) | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_ack | input | NCH (4) | Per-channel interrupt acknowledge, clears the flag |
| irq_req | output | NCH (4) | Per-channel interrupt request |
| irq_level | output | 2*NCH (8) | Packed 2-bit interrupt level per channel |

## Verification
The divider is tried at every clock select with a wait that ends part way through a division period, so an off-by-one tap or a divider that is not cleared on the select write shows up as a wrong count. Random periods and divide ratios combined with random waits tell a correct wrap at the period apart from a wrap at the counter's full width or one step early. Frequency mode is run with a small channel 0 top, so wrapping on the period and on the compare value give different counts. Flag timing is sampled one cycle before and on the matching edge, and the level, write-one-to-clear, acknowledge and the two commands are each checked through the register reads and interrupt pins.

// File: rtl/mctimer_pkg.sv
package mctimer_pkg;

  // Register word addresses
  localparam int unsigned RA_CLKSEL = 0;
  localparam int unsigned RA_MODE   = 1;
  localparam int unsigned RA_CMD    = 2;
  localparam int unsigned RA_PERIOD = 3;
  localparam int unsigned RA_COUNT  = 4;
  localparam int unsigned RA_LEVEL  = 5;
  localparam int unsigned RA_FLAGS  = 6;
  localparam int unsigned RA_CMP0   = 8;

  // Command bits
  localparam int unsigned CMD_RESET_BIT   = 0;
  localparam int unsigned CMD_RESTART_BIT = 1;

  // Divider span exponent for each clock select code
  function automatic logic [3:0] div_exp(input logic [2:0] sel);
    logic [3:0] e;
    case (sel)
      3'd1:    e = 4'd0;
      3'd2:    e = 4'd1;
      3'd3:    e = 4'd2;
      3'd4:    e = 4'd3;
      3'd5:    e = 4'd6;
      3'd6:    e = 4'd8;
      3'd7:    e = 4'd10;
      default: e = 4'd0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       clear,
  output logic       tick
);
  import mctimer_pkg::*;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] last_phase;
  logic             running;

  always_comb begin
    running    = (sel != 3'd0);
    last_phase = DIV_W'((32'd1 << div_exp(sel)) - 32'd1);
    tick       = running && (div_q == last_phase);
  end

  always_comb begin
    div_d = div_q;
    if (clear || !running || tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             step,
  output logic [CNT_W-1:0] count_nxt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    count_nxt = (cnt_q == top) ? '0 : cnt_q + 1'b1;
    step      = tick && !load && !clr;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d = count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/mct_channels.sv
module mct_channels #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic [CNT_W-1:0]     count_nxt,
  input  logic [NCH*CNT_W-1:0] cmp,
  input  logic [NCH-1:0]       clear_mask,
  input  logic [NCH-1:0]       ack,
  output logic [NCH-1:0]       flags
);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    logic flag_q, flag_d;

    always_comb begin
      hit    = step && (count_nxt == cmp[n*CNT_W +: CNT_W]);
      flag_d = flag_q;
      if (hit) begin
        flag_d = 1'b1;
      end else if (clr || clear_mask[n] || ack[n]) begin
        flag_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else begin
        flag_q <= flag_d;
      end
    end

    assign flags[n] = flag_q;
  end

endmodule

// File: rtl/mctimer.sv
module mctimer #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]    irq_ack,
  output logic [NCH-1:0]    irq_req,
  output logic [2*NCH-1:0]  irq_level
);
  import mctimer_pkg::*;

  localparam int LVL_W = 2 * NCH;

  // Configuration registers
  logic [2:0]                  clk_sel_q, clk_sel_d;
  logic                        mode_q, mode_d;
  logic [CNT_W-1:0]            period_q, period_d;
  logic [LVL_W-1:0]            levels_q, levels_d;
  logic [NCH-1:0][CNT_W-1:0]   cmp_q, cmp_d;

  // Decoded bus strobes
  logic wr_clksel, wr_mode, wr_cmd, wr_period, wr_count, wr_level, wr_flags;
  logic do_reset, do_restart;
  logic [NCH-1:0] wr_cmp;

  // Datapath links
  logic             tick, step;
  logic [CNT_W-1:0] count, count_nxt, top;
  logic [NCH-1:0]   flags, clear_mask;

  always_comb begin
    wr_clksel = bus_we && (bus_addr == ADDR_W'(RA_CLKSEL));
    wr_mode   = bus_we && (bus_addr == ADDR_W'(RA_MODE));
    wr_cmd    = bus_we && (bus_addr == ADDR_W'(RA_CMD));
    wr_period = bus_we && (bus_addr == ADDR_W'(RA_PERIOD));
    wr_count  = bus_we && (bus_addr == ADDR_W'(RA_COUNT));
    wr_level  = bus_we && (bus_addr == ADDR_W'(RA_LEVEL));
    wr_flags  = bus_we && (bus_addr == ADDR_W'(RA_FLAGS));
    for (int n = 0; n < NCH; n++) begin
      wr_cmp[n] = bus_we && (bus_addr == ADDR_W'(RA_CMP0 + n));
    end
    do_reset   = wr_cmd && bus_wdata[CMD_RESET_BIT];
    do_restart = wr_cmd && bus_wdata[CMD_RESTART_BIT] && !bus_wdata[CMD_RESET_BIT];
    clear_mask = wr_flags ? bus_wdata[NCH-1:0] : '0;
  end

  // Next-state of the configuration registers
  always_comb begin
    clk_sel_d = clk_sel_q;
    mode_d    = mode_q;
    period_d  = period_q;
    levels_d  = levels_q;
    cmp_d     = cmp_q;
    if (do_reset) begin
      clk_sel_d = '0;
      mode_d    = 1'b0;
      period_d  = '1;
      levels_d  = '0;
      cmp_d     = '0;
    end else begin
      if (wr_clksel) clk_sel_d = bus_wdata[2:0];
      if (wr_mode)   mode_d    = bus_wdata[0];
      if (wr_period) period_d  = bus_wdata;
      if (wr_level)  levels_d  = bus_wdata[LVL_W-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (wr_cmp[n]) cmp_d[n] = bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q <= '0;
      mode_q    <= 1'b0;
      period_q  <= '1;
      levels_q  <= '0;
      cmp_q     <= '0;
    end else begin
      clk_sel_q <= clk_sel_d;
      mode_q    <= mode_d;
      period_q  <= period_d;
      levels_q  <= levels_d;
      cmp_q     <= cmp_d;
    end
  end

  assign top = mode_q ? cmp_q[0] : period_q;

  mct_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (clk_sel_q),
    .clear (do_reset || do_restart || wr_clksel),
    .tick  (tick)
  );

  mct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (do_reset || do_restart),
    .load      (wr_count),
    .load_val  (bus_wdata),
    .tick      (tick),
    .top       (top),
    .count     (count),
    .step      (step),
    .count_nxt (count_nxt)
  );

  mct_channels #(.NCH(NCH), .CNT_W(CNT_W)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (do_reset),
    .step       (step),
    .count_nxt  (count_nxt),
    .cmp        (cmp_q),
    .clear_mask (clear_mask),
    .ack        (irq_ack),
    .flags      (flags)
  );

  // Interrupt outputs
  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      irq_req[n] = flags[n] && (levels_q[2*n +: 2] != 2'b00);
    end
    irq_level = levels_q;
  end

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(RA_CLKSEL)) bus_rdata = CNT_W'(clk_sel_q);
    if (bus_addr == ADDR_W'(RA_MODE))   bus_rdata = CNT_W'(mode_q);
    if (bus_addr == ADDR_W'(RA_PERIOD)) bus_rdata = period_q;
    if (bus_addr == ADDR_W'(RA_COUNT))  bus_rdata = count;
    if (bus_addr == ADDR_W'(RA_LEVEL))  bus_rdata = CNT_W'(levels_q);
    if (bus_addr == ADDR_W'(RA_FLAGS))  bus_rdata = CNT_W'(flags);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(RA_CMP0 + n)) bus_rdata = cmp_q[n];
    end
  end

endmodule

// File: rtl/mctimer_checker.sv
module mctimer_checker #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [NCH-1:0]       irq_ack,
  input logic [NCH-1:0]       irq_req,
  input logic [2*NCH-1:0]     irq_level,
  input logic [2:0]           clk_sel,
  input logic                 mode,
  input logic                 tick,
  input logic [CNT_W-1:0]     count,
  input logic [NCH-1:0]       flags,
  input logic [NCH*CNT_W-1:0] cmp
);

  // R2: a stopped counter holds
  p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !bus_we) |=> $stable(count));

  // R4: without bus traffic the counter only holds, steps by one, or wraps to 0
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)
                   || count == '0));

  // R5: frequency mode wraps after channel 0 top
  p_freq_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && tick && !bus_we && count == cmp[CNT_W-1:0]) |=> (count == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R6: a flag only rises when the counter lands on its compare value
    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[n]) |-> ($past(bus_we) || count == cmp[n*CNT_W +: CNT_W]));

    // R7: level zero masks the request
    p_level_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level[2*n +: 2] == 2'b00) |-> !irq_req[n]);

    // R9: acknowledge clears the flag when no match can occur
    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[n] && clk_sel == 3'd0 && !bus_we) |=> !flags[n]);
  end

endmodule

bind mctimer mctimer_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_mctimer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .irq_level (irq_level),
  .clk_sel   (clk_sel_q),
  .mode      (mode_q),
  .tick      (tick),
  .count     (count),
  .flags     (flags),
  .cmp       (cmp_q)
);

// File: tb/mctimer_bench.sv
module mctimer_bench;

  localparam int NCH = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_ack;
  logic [3:0]  irq_req;
  logic [7:0]  irq_level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [4:0] A_SEL = 5'd0, A_MODE = 5'd1, A_CMD = 5'd2, A_PER = 5'd3,
                         A_CNT = 5'd4, A_LVL = 5'd5, A_FLG = 5'd6, A_CMP = 5'd8;

  mctimer u_mctimer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int divide_of(input int sel);
    case (sel)
      1: return 1;  2: return 2;   3: return 4;    4: return 8;
      5: return 64; 6: return 256; 7: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] exp_count(input int k, input int div, input int per);
    return 16'((k / div) % (per + 1));
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_SEL, v); check("R1 clksel", v, 16'h0);
    rd(A_PER, v); check("R1 period", v, 16'hFFFF);
    rd(A_CNT, v); check("R1 count", v, 16'h0);
    rd(A_FLG, v); check("R1 flags", v, 16'h0);
    rd(A_CMP + 5'd2, v); check("R1 cmp2", v, 16'h0);
    check("R1 irq_req", {12'h0, irq_req}, 16'h0);

    // R2 stopped counter
    wait_n(20);
    rd(A_CNT, v); check("R2 stopped", v, 16'h0);

    // R3 every divide tap, wait ends mid-period
    for (int s = 1; s <= 7; s++) begin
      int dv, k;
      dv = divide_of(s);
      k  = 3 * dv + dv / 2;
      wr(A_SEL, 16'h0);
      wr(A_CNT, 16'h0);
      wr(A_SEL, 16'(s));
      wait_n(k);
      rd(A_CNT, v); check($sformatf("R3 sel %0d", s), v, exp_count(k, dv, 16'hFFFF));
    end

    // R4 random periods and divides
    for (int i = 0; i < 8; i++) begin
      int s, per, k;
      s   = 1 + int'($urandom % 4);
      per = 3 + int'($urandom % 40);
      k   = 1 + int'($urandom % 300);
      wr(A_SEL, 16'h0);
      wr(A_PER, 16'(per));
      wr(A_CNT, 16'h0);
      wr(A_SEL, 16'(s));
      wait_n(k);
      rd(A_CNT, v); check("R4 wrap at period", v, exp_count(k, divide_of(s), per));
    end
    // R4 directed: period 9, 25 steps
    wr(A_SEL, 16'h0); wr(A_PER, 16'd9); wr(A_CNT, 16'h0); wr(A_SEL, 16'd1);
    wait_n(25);
    rd(A_CNT, v); check("R4 period 9", v, 16'd5);
    wr(A_SEL, 16'h0); wr(A_PER, 16'hFFFF);

    // R10 counter load wins over step
    wr(A_CNT, 16'h0); wr(A_SEL, 16'd1);
    wr(A_CNT, 16'h1234);
    rd(A_CNT, v); check("R10 load", v, 16'h1234);
    wait_n(3);
    rd(A_CNT, v); check("R10 after load", v, 16'h1237);

    // R5 frequency mode, channel 0 top = 4
    wr(A_SEL, 16'h0); wr(A_MODE, 16'h1); wr(A_CMP, 16'd4);
    wr(A_CNT, 16'h0); wr(A_FLG, 16'hF); wr(A_SEL, 16'd1);
    wait_n(12);
    rd(A_CNT, v); check("R5 freq count", v, 16'd2);
    rd(A_FLG, v); check("R5 ch0 flag", {15'h0, v[0]}, 16'h1);
    wr(A_SEL, 16'h0); wr(A_MODE, 16'h0);

    // R6 flag timing on channel 1, compare 7
    wr(A_CMP + 5'd1, 16'd7); wr(A_CNT, 16'h0); wr(A_FLG, 16'hF); wr(A_SEL, 16'd1);
    wait_n(6);
    rd(A_FLG, v); check("R6 before match", {15'h0, v[1]}, 16'h0);
    wait_n(1);
    rd(A_FLG, v); check("R6 on match", {15'h0, v[1]}, 16'h1);
    wr(A_SEL, 16'h0);

    // R7 level gating and placement
    check("R7 level 0 masks", {15'h0, irq_req[1]}, 16'h0);
    wr(A_LVL, 16'h0008);
    check("R7 request", {15'h0, irq_req[1]}, 16'h1);
    check("R7 level bits", {14'h0, irq_level[3:2]}, 16'h2);
    check("R7 ch0 masked", {15'h0, irq_req[0]}, 16'h0);

    // R8 write-one-to-clear on channel 0 only
    wr(A_FLG, 16'h0001);
    rd(A_FLG, v); check("R8 w1c", v, 16'h0002);

    // R9 acknowledge
    @(negedge clk); irq_ack = 4'b0010;
    @(negedge clk); irq_ack = 4'b0000;
    rd(A_FLG, v); check("R9 ack flag", v, 16'h0);
    check("R9 ack irq", {12'h0, irq_req}, 16'h0);

    // R12 restart
    wr(A_CNT, 16'h0055); wr(A_SEL, 16'd4);
    wait_n(20);
    wr(A_CMD, 16'h0002);
    rd(A_CNT, v); check("R12 count zero", v, 16'h0);
    rd(A_SEL, v); check("R12 clksel kept", v, 16'd4);
    rd(A_LVL, v); check("R12 level kept", v, 16'h0008);
    wait_n(7);
    rd(A_CNT, v); check("R12 full phase", v, 16'h0);
    wait_n(1);
    rd(A_CNT, v); check("R12 first step", v, 16'h1);

    // R11 reset command
    wr(A_MODE, 16'h1); wr(A_PER, 16'h0100);
    wr(A_CMD, 16'h0001);
    rd(A_SEL, v);  check("R11 clksel", v, 16'h0);
    rd(A_MODE, v); check("R11 mode", v, 16'h0);
    rd(A_PER, v);  check("R11 period", v, 16'hFFFF);
    rd(A_CMP + 5'd1, v); check("R11 cmp1", v, 16'h0);
    rd(A_LVL, v);  check("R11 levels", v, 16'h0);
    rd(A_CNT, v);  check("R11 count", v, 16'h0);
    wait_n(5);
    rd(A_CNT, v);  check("R11 stopped", v, 16'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule